// File: doc/BRIEF.md
# Soft power wake-up controller

This block decides whether the system is powered. It sits in the always-on, battery-fed domain and drives an active-low power-on output. Fifteen wake-up event inputs are recorded in two status registers. An event turns the system on only if its bit in the matching enable register is set.

While the system is on, it can be powered down in two ways. Software can write a power-off request bit. A button override event can also start the power-down, but only while its own enable bit is set. Either way, power drops only after a programmable delay, which is counted in ticks of a 1 kHz strobe. Software can stop the delay or restart it. All registers are reset only by the battery power-on reset, so their contents survive system power cycles.

Top module: `softpwr_ctl`

## Requirements
- R1: After battery reset the registers read as follows: address 0 (wake enable low) reads 0x00, address 1 (wake enable high) reads 0x80, addresses 2 and 3 (status) read 0x00, address 4 (control) reads 0x00 and address 5 (delay) reads 0x00. The output pwr_on_n reads 1 (off).
- R2: A pulse on wake_evt[i] sets the matching status bit on the next clock edge, whatever the enable bits hold. Events 0 to 7 map to bits 7:0 of address 2. Events 8 to 14 map to bits 6:0 of address 3, and bit 7 of address 3 reads 0.
- R3: While the system is off, a wake event whose enable bit is 1 drives pwr_on_n low on the next clock edge. Enable bits 7:0 of address 0 gate events 7:0, and bits 6:0 of address 1 gate events 8:14. An event whose enable bit is 0 leaves the system off.
- R4: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an event arrives in the same cycle as a clearing write, the bit stays set.
- R5: While the system is on, writing 1 to control bit 7 starts a power-off delay. Control bit 7 then reads 1 until the delay ends. pwr_on_n goes high on the clock edge that samples the Nth tick after the request, where N = 500 × (delay value + 1).
- R6: Bit 7 of address 1 enables the button power-off. With the bit set, a btn_off pulse while on starts the same delay as R5. With the bit cleared, btn_off is ignored.
- R7: The delay register at address 5 keeps only the low 6 bits of a write, and its upper bits read 0. Value v gives a delay of v+1 units of 500 ticks, so 0 gives 500 ticks and 63 gives 32000 ticks.
- R8: While a delay runs, writing 1 to control bit 6 reloads the full delay. Writing 1 to control bit 5 cancels the delay and the system stays on. If both bits are written together, the cancel takes effect.
- R9: A power-off request while a delay already runs does not reload the count. A request while the system is off has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| vbat_rst_n | input | 1 | Battery power-on reset, active low, asynchronous |
| tick_1k | input | 1 | One-cycle strobe at 1 kHz that paces the delay |
| wake_evt | input | 15 | Wake-up event pulses |
| btn_off | input | 1 | Button power-off override event pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| pwr_on_n | output | 1 | Power-on output, low while the system is on |

## Verification
Register reads are combinational, so they are sampled within the same low clock phase in which the address is set. Status bits and the power state change on the edge that follows an event or write, so the bench checks them at the falling edge after that edge. For the power-off delay, the bench issues N-1 ticks and confirms the system is still on. It then issues the final tick and confirms pwr_on_n is high at the next falling edge, which pins the delay to its exact tick.

// File: rtl/softpwr_ctl.sv
module softpwr_ctl #(
  parameter int TICKS_PER_UNIT = 500,
  parameter int DLY_W = 6,
  parameter int NEV = 15
) (
  input  logic           clk,
  input  logic           vbat_rst_n,
  input  logic           tick_1k,
  input  logic [NEV-1:0] wake_evt,
  input  logic           btn_off,
  input  logic           reg_wr,
  input  logic [2:0]     reg_addr,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata,
  output logic           pwr_on_n
);
  localparam int MAXU = 1 << DLY_W;
  localparam int MAXT = MAXU * TICKS_PER_UNIT;
  localparam int CW = $clog2(MAXT + 1);
  localparam int HI = NEV - 8;

  logic [7:0]       en1, en2, st1;
  logic [HI-1:0]    st2;
  logic [DLY_W-1:0] dly;
  logic             on, pend;
  logic [CW-1:0]    cnt;

  wire wr_en1  = reg_wr && reg_addr == 3'd0;
  wire wr_en2  = reg_wr && reg_addr == 3'd1;
  wire wr_st1  = reg_wr && reg_addr == 3'd2;
  wire wr_st2  = reg_wr && reg_addr == 3'd3;
  wire wr_ctrl = reg_wr && reg_addr == 3'd4;
  wire wr_dly  = reg_wr && reg_addr == 3'd5;

  wire [NEV-1:0] en_all = {en2[HI-1:0], en1};
  wire wake_hit = |(wake_evt & en_all);
  wire req_off  = (wr_ctrl && reg_wdata[7]) || (btn_off && en2[7]);
  wire do_rst   = wr_ctrl && reg_wdata[6];
  wire do_stop  = wr_ctrl && reg_wdata[5];
  wire [CW-1:0] load = (CW'(dly) + CW'(1)) * CW'(TICKS_PER_UNIT);

  always_ff @(posedge clk or negedge vbat_rst_n) begin
    if (!vbat_rst_n) begin
      en1 <= '0;
      en2 <= 8'h80;
      st1 <= '0;
      st2 <= '0;
      dly <= '0;
    end else begin
      if (wr_en1) en1 <= reg_wdata;
      if (wr_en2) en2 <= reg_wdata;
      if (wr_dly) dly <= reg_wdata[DLY_W-1:0];
      st1 <= (st1 & ~(wr_st1 ? reg_wdata : 8'h00)) | wake_evt[7:0];
      st2 <= (st2 & ~(wr_st2 ? reg_wdata[HI-1:0] : '0)) | wake_evt[NEV-1:8];
    end
  end

  always_ff @(posedge clk or negedge vbat_rst_n) begin
    if (!vbat_rst_n) begin
      on   <= 1'b0;
      pend <= 1'b0;
      cnt  <= '0;
    end else if (!on) begin
      pend <= 1'b0;
      if (wake_hit) on <= 1'b1;
    end else if (do_stop) begin
      pend <= 1'b0;
    end else if (!pend) begin
      if (req_off) begin
        pend <= 1'b1;
        cnt  <= load;
      end
    end else if (do_rst) begin
      cnt <= load;
    end else if (tick_1k) begin
      if (cnt == CW'(1)) begin
        pend <= 1'b0;
        on   <= 1'b0;
      end else begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = en1;
      3'd1:    reg_rdata = en2;
      3'd2:    reg_rdata = st1;
      3'd3:    reg_rdata = 8'(st2);
      3'd4:    reg_rdata = {pend, 7'b0};
      3'd5:    reg_rdata = 8'(dly);
      default: reg_rdata = 8'h00;
    endcase
  end

  assign pwr_on_n = !on;

  AST_STATUS_LATCH: assert property (@(posedge clk) disable iff (!vbat_rst_n)
    wake_evt != '0 |=> ({st2, st1} & $past(wake_evt)) == $past(wake_evt)); // R2
  AST_WAKE_ON: assert property (@(posedge clk) disable iff (!vbat_rst_n)
    (pwr_on_n && wake_hit) |=> !pwr_on_n); // R3
  AST_STAY_OFF: assert property (@(posedge clk) disable iff (!vbat_rst_n)
    (pwr_on_n && (wake_evt & en_all) == '0) |=> pwr_on_n); // R3
  AST_W1C: assert property (@(posedge clk) disable iff (!vbat_rst_n)
    (wr_st1 && (reg_wdata & ~wake_evt[7:0]) != 8'h00) |=> (st1 & $past(reg_wdata & ~wake_evt[7:0])) == 8'h00); // R4
  AST_OFF_NEEDS_DELAY: assert property (@(posedge clk) disable iff (!vbat_rst_n)
    (!pwr_on_n && !pend) |=> !pwr_on_n); // R5
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!vbat_rst_n)
    pend |-> (cnt != '0 && cnt <= CW'(MAXT))); // R7
endmodule

// File: tb/sim_softpwr_ctl.sv
module sim_softpwr_ctl;
  logic clk = 1'b0;
  logic vbat_rst_n = 1'b0;
  logic tick_1k = 1'b0;
  logic [14:0] wake_evt = '0;
  logic btn_off = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic pwr_on_n;
  int total = 0;
  int bad = 0;

  softpwr_ctl u0 (.clk(clk), .vbat_rst_n(vbat_rst_n), .tick_1k(tick_1k), .wake_evt(wake_evt),
    .btn_off(btn_off), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pwr_on_n(pwr_on_n));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic pwr(input string tag, input logic exp);
    chk(tag, {7'b0, pwr_on_n}, {7'b0, exp});
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wake(input logic [14:0] m);
    @(negedge clk);
    wake_evt = m;
    @(negedge clk);
    wake_evt = '0;
  endtask

  task automatic button;
    @(negedge clk);
    btn_off = 1'b1;
    @(negedge clk);
    btn_off = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_1k = 1'b1;
      @(negedge clk);
      tick_1k = 1'b0;
    end
  endtask

  task automatic t_reset;
    rd("R1 en1", 3'd0, 8'h00);
    rd("R1 en2", 3'd1, 8'h80);
    rd("R1 st1", 3'd2, 8'h00);
    rd("R1 st2", 3'd3, 8'h00);
    rd("R1 ctrl", 3'd4, 8'h00);
    rd("R1 dly", 3'd5, 8'h00);
    pwr("R1 pwr", 1'b1);
  endtask

  task automatic t_status;
    wake(15'h0005);
    rd("R2 st1 latch", 3'd2, 8'h05);
    pwr("R3 disabled stays off", 1'b1);
    wake(15'h4100);
    rd("R2 st2 latch", 3'd3, 8'h41);
    rd("R2 st1 kept", 3'd2, 8'h05);
  endtask

  task automatic t_w1c;
    wr(3'd2, 8'h01);
    rd("R4 clear one", 3'd2, 8'h04);
    wr(3'd2, 8'h00);
    rd("R4 zero no effect", 3'd2, 8'h04);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 8'h04; wake_evt = 15'h0004;
    @(negedge clk);
    reg_wr = 1'b0; wake_evt = '0;
    rd("R4 set wins", 3'd2, 8'h04);
    wr(3'd2, 8'hFF);
    wr(3'd3, 8'hFF);
    rd("R4 st1 cleared", 3'd2, 8'h00);
    rd("R4 st2 cleared", 3'd3, 8'h00);
  endtask

  task automatic t_wake;
    wr(3'd0, 8'h02);
    wake(15'h0001);
    pwr("R3 bit0 disabled", 1'b1);
    wake(15'h0002);
    pwr("R3 bit1 enabled on", 1'b0);
  endtask

  task automatic t_swoff;
    wr(3'd4, 8'h80);
    rd("R5 pending", 3'd4, 8'h80);
    ticks(499);
    pwr("R5 before last tick", 1'b0);
    ticks(1);
    pwr("R5 off at 500", 1'b1);
    rd("R5 pending cleared", 3'd4, 8'h00);
    wake(15'h0002);
    pwr("R3 rewake", 1'b0);
  endtask

  task automatic t_dly;
    wr(3'd5, 8'hFF);
    rd("R7 six bits", 3'd5, 8'h3F);
    wr(3'd5, 8'h02);
    rd("R7 readback", 3'd5, 8'h02);
    wr(3'd4, 8'h80);
    ticks(1499);
    pwr("R7 before 1500", 1'b0);
    ticks(1);
    pwr("R7 off at 1500", 1'b1);
    wr(3'd5, 8'h00);
    wake(15'h0002);
  endtask

  task automatic t_btn;
    wr(3'd1, 8'h00);
    button();
    rd("R6 disabled ignored", 3'd4, 8'h00);
    wr(3'd1, 8'h80);
    button();
    rd("R6 enabled pending", 3'd4, 8'h80);
    ticks(499);
    pwr("R6 before 500", 1'b0);
    ticks(1);
    pwr("R6 off", 1'b1);
    wake(15'h0002);
  endtask

  task automatic t_restart;
    wr(3'd4, 8'h80);
    ticks(300);
    wr(3'd4, 8'h40);
    ticks(499);
    pwr("R8 restart reloads", 1'b0);
    ticks(1);
    pwr("R8 off after reload", 1'b1);
    wake(15'h0002);
    wr(3'd4, 8'h80);
    ticks(100);
    wr(3'd4, 8'h60);
    rd("R8 stop wins", 3'd4, 8'h00);
    ticks(600);
    pwr("R8 stop keeps on", 1'b0);
  endtask

  task automatic t_repeat;
    wr(3'd4, 8'h80);
    ticks(400);
    wr(3'd4, 8'h80);
    ticks(99);
    pwr("R9 no reload before", 1'b0);
    ticks(1);
    pwr("R9 off at original", 1'b1);
    wr(3'd4, 8'h80);
    rd("R9 off request ignored", 3'd4, 8'h00);
    ticks(600);
    pwr("R9 stays off", 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    vbat_rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_status();
    t_w1c();
    t_wake();
    t_swoff();
    t_dly();
    t_btn();
    t_restart();
    t_repeat();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule